// File: doc/BRIEF.md
# Transmit Frame Padder and Checksum Appender

This block is a byte-wide stage on the transmit side of an Ethernet MAC. It sits between the frame source and the serializer. Each frame arrives as a stream of bytes. The first byte carries a start marker and the final byte carries an end marker. Two per-frame controls come with the stream: one asks for short frames to be padded, the other asks for the checksum to be left off. The stage forwards the data bytes with no added latency. It then appends zero bytes when the frame is too short. Last, it appends the four-byte CRC-32 frame check sequence.

The minimum frame size includes the check sequence, so padding stops at 60 bytes of data plus pad. The checksum is calculated over the pad bytes as well as the data. Turning padding on forces the checksum to be sent, whatever the checksum-disable control says. While pad or checksum bytes are leaving, the input is stalled. Both streams use a valid/ready handshake.

Top module: `tx_pad_fcs`

## Requirements
- R1: Data bytes leave on `out_data` unchanged and in their arrival order. A data byte appears in the same cycle it is accepted.
- R2: With padding on and fewer than 60 data bytes, zero-valued bytes follow the data until data plus pad reach 60 bytes. The frame, including the check sequence, is then 64 bytes.
- R3: A frame of 60 or more data bytes gets no pad bytes, whatever the controls say.
- R4: The check sequence is the reflected CRC-32 (polynomial 04C11DB7h, preset all ones, result inverted). It covers the data and pad bytes and follows the pad. It is sent least significant byte first, so the 9-byte ASCII string "123456789" yields bytes 26h, 39h, F4h, CBh.
- R5: With padding on, the check sequence is appended even when `fcs_off` is 1.
- R6: With padding off and `fcs_off` at 1, the frame leaves with exactly its data bytes, and `out_last` marks the final data byte.
- R7: With padding off and `fcs_off` at 0, the check sequence follows the data directly and no pad is added, even for a short frame.
- R8: `in_ready` stays low while pad or check-sequence bytes are being sent. No input byte is accepted until the frame's last byte has left.
- R9: `out_last` is high on the frame's final output byte only.
- R10: `pad_en` and `fcs_off` are sampled with the byte that carries `in_first`. Changes later in the frame have no effect on that frame.
- R11: While `out_ready` is low during pad or check-sequence output, `out_valid` stays high and `out_data` and `out_last` hold their values.
- R12: After reset, with no input offered, `out_valid` is low and the stage is ready to accept a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_data | input | 8 | Input frame byte |
| in_first | input | 1 | Marks the first byte of a frame |
| in_last | input | 1 | Marks the final data byte of a frame |
| pad_en | input | 1 | Pad short frames (also forces the check sequence) |
| fcs_off | input | 1 | Leave off the check sequence when padding is off |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Marks the final output byte of a frame |

## Verification
The closest collisions happen at frame boundaries. In a single handshake, the byte carrying `in_last` must both finish the CRC and pick the next phase: pad, check sequence, or none. The first byte of the next frame can also arrive in the cycle right after the previous `out_last`, which reloads the CRC and resamples the controls. Frames of exactly 59 and 60 data bytes, and a frame that flips the controls after its first byte, exercise the first case. Frames are sent back to back with the next start offered immediately, which exercises the second. The bench judges each case by comparing the whole output stream, including its length and the position of `out_last`, with a frame it builds independently.

// File: rtl/tx_pad_fcs.sv
module tx_pad_fcs #(
  parameter int MIN_FRAME = 64,
  parameter int FCS_LEN   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_first,
  input  logic       in_last,
  input  logic       pad_en,
  input  logic       fcs_off,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);
  localparam int MIN_DATA = MIN_FRAME - FCS_LEN;
  localparam int CW = $clog2(MIN_DATA + 1);
  localparam int IW = $clog2(FCS_LEN);
  localparam int LW = $clog2(MIN_FRAME + 1);

  typedef enum logic [1:0] {S_DATA, S_PAD, S_FCS} phase_t;

  phase_t          state;
  logic [CW-1:0]   cnt;
  logic [31:0]     crc;
  logic [IW-1:0]   fidx;
  logic            pad_h, fo_h;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  wire start    = (state == S_DATA) && in_first;
  wire eff_pe   = start ? pad_en  : pad_h;
  wire eff_fo   = start ? fcs_off : fo_h;
  wire want_fcs = eff_pe || !eff_fo;
  wire out_fire = out_valid && out_ready;

  wire [CW-1:0] cnt_base = start ? '0 : cnt;
  wire [CW-1:0] cnt_inc  = (cnt_base == CW'(MIN_DATA)) ? cnt_base : cnt_base + 1'b1;
  wire          need_pad = eff_pe && (cnt_inc < CW'(MIN_DATA));

  wire [31:0] crc_base = start ? 32'hFFFF_FFFF : crc;
  wire [31:0] crc_next = crc_byte(crc_base, (state == S_PAD) ? 8'h00 : in_data);
  wire [31:0] fcs_word = ~crc;
  wire        fcs_end  = (fidx == IW'(FCS_LEN - 1));

  assign in_ready  = (state == S_DATA) && out_ready;
  assign out_valid = (state == S_DATA) ? in_valid : 1'b1;

  always_comb begin
    case (state)
      S_PAD:   out_data = 8'h00;
      S_FCS:   out_data = fcs_word[8*fidx +: 8];
      default: out_data = in_data;
    endcase
  end

  always_comb begin
    case (state)
      S_FCS:   out_last = fcs_end;
      S_DATA:  out_last = in_last && !want_fcs;
      default: out_last = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_DATA;
      cnt   <= '0;
      crc   <= 32'hFFFF_FFFF;
      fidx  <= '0;
      pad_h <= 1'b0;
      fo_h  <= 1'b0;
    end else if (out_fire) begin
      case (state)
        S_DATA: begin
          cnt <= cnt_inc;
          crc <= crc_next;
          if (start) begin
            pad_h <= pad_en;
            fo_h  <= fcs_off;
          end
          if (in_last) begin
            fidx <= '0;
            if (need_pad)      state <= S_PAD;
            else if (want_fcs) state <= S_FCS;
          end
        end
        S_PAD: begin
          cnt <= cnt_inc;
          crc <= crc_next;
          if (cnt_inc == CW'(MIN_DATA)) state <= S_FCS;
        end
        default: begin
          fidx <= fidx + 1'b1;
          if (fcs_end) state <= S_DATA;
        end
      endcase
    end
  end

  logic [LW-1:0] chk_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_len <= '0;
    else if (out_fire) begin
      if (out_last) chk_len <= '0;
      else if (chk_len != LW'(MIN_FRAME)) chk_len <= chk_len + 1'b1;
    end
  end

  AST_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_last && (state == S_FCS) && pad_h |-> chk_len >= LW'(MIN_FRAME - 1)); // R2
  AST_NO_INPUT_IN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_DATA) |-> !(in_valid && in_ready)); // R8
  AST_TAIL_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_DATA) && out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R11
  AST_TAIL_NEEDS_FCS: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && (state != S_DATA) |-> (pad_h || !fo_h)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MIN_DATA)); // R3
endmodule

// File: tb/test_tx_pad_fcs.sv
module test_tx_pad_fcs;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_first = 0, in_last = 0, pad_en = 0, fcs_off = 0, out_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;

  tx_pad_fcs i_tx_pad_fcs (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .pad_en(pad_en), .fcs_off(fcs_off),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [7:0] obuf [0:255];
  logic       olast [0:255];
  int ocount = 0, tail_in = 0, stall_err = 0;
  logic tail = 0, seen_last = 0, prev_stall = 0;
  logic [7:0] prev_data;

  always @(negedge clk) begin
    if (tail && prev_stall && (!out_valid || out_data != prev_data)) stall_err++;
    prev_stall = tail && out_valid && !out_ready;
    prev_data  = out_data;
    if (out_valid && out_ready) begin
      if (ocount < 256) begin obuf[ocount] = out_data; olast[ocount] = out_last; end
      ocount++;
      if (out_last) seen_last = 1;
    end
    if (tail && in_valid && in_ready) tail_in++;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic b = r[0] ^ d[k];
      r = r >> 1;
      if (b) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  logic [7:0] din [0:127];

  task automatic run_frame(string req, int len, bit pe, bit fo, bit flip, bit stall, bit ascii);
    logic [7:0] exp [0:135];
    int elen, i, cyc, bad, early;
    logic [31:0] c;
    bit fire;
    for (int k = 0; k < len; k++) din[k] = ascii ? 8'(8'h31 + k) : 8'(k * 37 + len);
    elen = len;
    for (int k = 0; k < len; k++) exp[k] = din[k];
    if (pe) while (elen < 60) begin exp[elen] = 8'h00; elen++; end
    if (pe || !fo) begin
      c = 32'hFFFF_FFFF;
      for (int k = 0; k < elen; k++) c = ref_crc(c, exp[k]);
      c = ~c;
      for (int k = 0; k < 4; k++) exp[elen + k] = c[8*k +: 8];
      elen += 4;
    end
    ocount = 0; seen_last = 0; tail_in = 0; stall_err = 0;
    i = 0; cyc = 0;
    while (i < len && cyc < 3000) begin
      in_valid = 1; in_data = din[i]; in_first = (i == 0); in_last = (i == len - 1);
      pad_en  = (flip && i > 0) ? !pe : pe;
      fcs_off = (flip && i > 0) ? !fo : fo;
      out_ready = stall ? (cyc % 3 != 2) : 1'b1;
      @(negedge clk); fire = in_ready;
      @(posedge clk); #1; cyc++;
      if (fire) i++;
    end
    tail = 1; in_valid = 1; in_data = 8'hA5; in_first = 0; in_last = 0;
    while (!seen_last && cyc < 3000) begin
      out_ready = stall ? (cyc % 3 != 2) : 1'b1;
      @(negedge clk); @(posedge clk); #1; cyc++;
    end
    tail = 0; in_valid = 0; out_ready = 1;
    chk(ocount == elen, req, "frame length", ocount, elen);
    bad = 0; early = 0;
    for (int k = 0; k < ocount && k < elen && k < 256; k++) begin
      if (obuf[k] != exp[k]) bad++;
      if (olast[k] != (k == elen - 1)) early++;
    end
    chk(bad == 0, req, "R1/R4 byte mismatches", bad, 0);
    chk(early == 0, req, "R9 misplaced out_last", early, 0);
    if (elen > len) chk(tail_in == 0, "R8", "inputs accepted during tail", tail_in, 0);
    if (stall) chk(stall_err == 0, "R11", "tail changed under stall", stall_err, 0);
  endtask

  task automatic t_reset();
    rst_n = 0; in_valid = 0; out_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R12", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R12", "in_ready after reset", in_ready, 1);
    @(posedge clk); #1;
  endtask

  task automatic t_crc_vector();
    run_frame("R7", 9, 0, 0, 0, 0, 1);
    chk({obuf[12], obuf[11], obuf[10], obuf[9]} == 32'hCBF43926, "R4", "check value of 123456789",
        int'({obuf[12], obuf[11], obuf[10], obuf[9]}), int'(32'hCBF43926));
  endtask

  task automatic t_short_pad();     run_frame("R2", 10, 1, 0, 0, 0, 0); endtask
  task automatic t_forced_fcs();    run_frame("R5", 1, 1, 1, 0, 0, 0); endtask
  task automatic t_edge59();        run_frame("R2", 59, 1, 0, 0, 0, 0); endtask
  task automatic t_edge60();        run_frame("R3", 60, 1, 1, 0, 0, 0); endtask
  task automatic t_long();          run_frame("R3", 100, 1, 0, 0, 0, 0); endtask
  task automatic t_raw();           run_frame("R6", 20, 0, 1, 0, 0, 0); endtask
  task automatic t_fcs_no_pad();    run_frame("R7", 12, 0, 0, 0, 0, 0); endtask
  task automatic t_flip_to_pad();   run_frame("R10", 15, 0, 1, 1, 0, 0); endtask
  task automatic t_flip_to_raw();   run_frame("R10", 15, 1, 0, 1, 0, 0); endtask
  task automatic t_stall();         run_frame("R11", 30, 1, 0, 0, 1, 0); endtask

  initial begin
    t_reset();
    t_crc_vector();
    t_short_pad();
    t_forced_fcs();
    t_edge59();
    t_edge60();
    t_long();
    t_raw();
    t_fcs_no_pad();
    t_flip_to_pad();
    t_flip_to_raw();
    t_stall();
    summary();
  end
endmodule